// File: doc/BRIEF.md
# Accumulator ALU with Flags

This block is the 8-bit arithmetic and logic datapath of a small accumulator CPU. Each cycle the sequencer may hand it one operation: an operation code, a target operand (the accumulator or the read-modify-write byte), a second operand (the memory byte, or the low index byte for multiply) and the current condition code byte. One clock later the block returns the result byte, a high result byte (used only by multiply), a write-back enable, and the new condition code byte. The carry input of the carrying operations is taken from the C bit of the incoming condition code byte.

The condition code byte has a fixed layout: V at bit 7, two constant ones at bits 6 and 5, H at bit 4, I at bit 3, N at bit 2, Z at bit 1 and C at bit 0. Every operation class has its own rule for which flags it writes, forces or keeps. Compare and the two test operations only produce flags, so their write-back enable is low.

The block has no memory access and no addressing. Division and decimal adjust are left to other logic.

Top module: `acc_alu`

## Requirements
- R1: Inputs are captured on a rising clock edge with `in_valid` high, and the results appear on the outputs from that edge with `out_valid` high for exactly one cycle. After synchronous active-low reset `out_valid`, `wr_en`, `res_lo` and `res_hi` are 0 and `ccr_out` is 0x60.
- R2: In `ccr_out` V is bit 7, H is bit 4, I is bit 3, N is bit 2, Z is bit 1, C is bit 0, and bits 6 and 5 always read 1. I always equals the I bit of `ccr_in`. H equals the incoming H for every operation except multiply. `res_hi` is 0 for every operation except multiply.
- R3: Subtract (op 0) gives `opa - opb`. Subtract with carry (op 1) gives `opa - opb - C`. Compare (op 2) computes the same flags as op 0 with `wr_en` low. C is set when the unsigned `opa` is smaller than `opb` plus the borrow. V is set on signed overflow. N is result bit 7, and Z is set when the result is zero.
- R4: Negate (op 3) gives `0x00 - opa`, with C = (result != 0), V = (result == 0x80), and N and Z taken from the result.
- R5: Increment (op 4) and decrement (op 5) give `opa + 1` and `opa - 1`. V is set when the result is 0x80 for increment and 0x7F for decrement. N and Z follow the result, and C is unchanged.
- R6: AND (op 6), bit test (op 7, `wr_en` low), exclusive OR (op 8), inclusive OR (op 9), load (op 10, result `opb`) and test (op 11, result `opa`, `wr_en` low) force V to 0, set N and Z from the result and leave C unchanged.
- R7: Ones complement (op 12) gives `~opa`, forces V to 0 and C to 1, and sets N and Z from the result.
- R8: Clear (op 13) gives 0x00, forces V and N to 0 and Z to 1, and leaves C unchanged.
- R9: Shift left (op 14) puts 0 in bit 0, and rotate left (op 16) puts the old C in bit 0. For both, C becomes `opa` bit 7, N and Z follow the result, and V = N xor C.
- R10: Logical shift right (op 15) puts 0 in bit 7 and so forces N to 0. Rotate right (op 17) puts the old C in bit 7. For both, C becomes `opa` bit 0, Z follows the result, and V = N xor C.
- R11: Nibble swap (op 18) gives `{opa[3:0], opa[7:4]}` and leaves all flags unchanged.
- R12: Multiply (op 19) gives the unsigned 16-bit product `opa * opb`, with the high byte on `res_hi` and the low byte on `res_lo`. It clears H and C and leaves V, N and Z unchanged.
- R13: Codes 20 to 31 are unassigned. For these codes `wr_en` is low, both results are 0 and all flags are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An operation is presented this cycle |
| op | input | 5 | Operation code (see requirements) |
| opa | input | 8 | Target operand: accumulator or read-modify-write byte |
| opb | input | 8 | Second operand: memory byte, or index low byte for multiply |
| ccr_in | input | 8 | Current condition code byte; its C bit is the carry input |
| out_valid | output | 1 | Results below belong to the operation of the previous cycle |
| res_hi | output | 8 | Product high byte for multiply, else 0 |
| res_lo | output | 8 | Result byte |
| wr_en | output | 1 | Result must be written back to its destination |
| ccr_out | output | 8 | Updated condition code byte |

## Verification
The hardest cases to reach are the flag edges that depend on one exact operand value or on the carry input together with the operand. Examples are subtract with carry where the borrow alone turns an equal pair into a borrow, negate of 0x80 and 0x00, increment of 0x7F, decrement of 0x80, and rotations that must carry the old C into the vacated bit. The stimulus sets these up with directed operand and condition code values before a long run of random operands, random codes (including unassigned ones) and random incoming condition code bytes. That random run makes sure the kept flags, H and I, pass through with both polarities. A reference model in the bench predicts every result into a scoreboard queue.

// File: rtl/acc_alu_pkg.sv
// acc_alu_pkg
// Shared widths, condition code bit positions, operation codes and the
// flag bundle used by every unit of the accumulator ALU.
// Assumes an 8-bit condition code byte with a fixed bit layout.
package acc_alu_pkg;

    localparam int DATA_W = 8;
    localparam int OP_W   = 5;
    localparam int CCR_W  = 8;

    // Condition code bit positions; the sequencer decodes these.
    localparam int CCR_V = 7;
    localparam int CCR_H = 4;
    localparam int CCR_I = 3;
    localparam int CCR_N = 2;
    localparam int CCR_Z = 1;
    localparam int CCR_C = 0;

    // Bits that always read as one.
    localparam logic [CCR_W-1:0] CCR_ONES = 8'h60;

    typedef enum logic [OP_W-1:0] {
        OP_SUB = 5'd0,
        OP_SBC = 5'd1,
        OP_CMP = 5'd2,
        OP_NEG = 5'd3,
        OP_INC = 5'd4,
        OP_DEC = 5'd5,
        OP_AND = 5'd6,
        OP_BIT = 5'd7,
        OP_EOR = 5'd8,
        OP_ORA = 5'd9,
        OP_LDA = 5'd10,
        OP_TST = 5'd11,
        OP_COM = 5'd12,
        OP_CLR = 5'd13,
        OP_LSL = 5'd14,
        OP_LSR = 5'd15,
        OP_ROL = 5'd16,
        OP_ROR = 5'd17,
        OP_NSA = 5'd18,
        OP_MUL = 5'd19
    } alu_op_e;

    // Writable flags; I is handled outside the units and never altered.
    typedef struct packed {
        logic v;
        logic h;
        logic n;
        logic z;
        logic c;
    } flags_t;

endpackage

// File: rtl/acc_alu_arith.sv
// acc_alu_arith
// Subtract-family and step operations: subtract, subtract with carry,
// compare, negate, increment and decrement. Flags not named by an
// operation are passed from fl_i unchanged.
// Assumes W >= 2; the carry input is fl_i.c.
module acc_alu_arith
    import acc_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [OP_W-1:0] op_i,
    input  logic [W-1:0]    a_i,
    input  logic [W-1:0]    b_i,
    input  flags_t          fl_i,
    output logic            sel_o,
    output logic [W-1:0]    res_o,
    output flags_t          fl_o
);

    localparam int MSB = W - 1;

    logic [W-1:0] minu;
    logic [W-1:0] subt;
    logic         bin;
    logic [W:0]   diff;
    logic [W-1:0] step;

    // Choose minuend, subtrahend and borrow-in for the shared subtractor.
    always_comb begin
        minu = a_i;
        subt = b_i;
        bin  = 1'b0;
        case (op_i)
            OP_SBC:  bin  = fl_i.c;
            OP_NEG:  begin minu = '0; subt = a_i; end
            OP_DEC:  subt = W'(1);
            default: ;
        endcase
    end

    // Shared subtractor with borrow out in the top bit; separate incrementer.
    always_comb begin
        diff = {1'b0, minu} - {1'b0, subt} - {{W{1'b0}}, bin};
        step = a_i + W'(1);
    end

    // Result, class select and per-operation flag rule.
    always_comb begin
        fl_o  = fl_i;
        res_o = diff[W-1:0];
        sel_o = 1'b1;
        case (op_i)
            OP_SUB, OP_SBC, OP_CMP, OP_NEG: begin
                fl_o.c = diff[W];
                fl_o.v = (minu[MSB] ^ subt[MSB]) & (minu[MSB] ^ diff[MSB]);
            end
            OP_DEC: begin
                fl_o.v = (minu[MSB] ^ subt[MSB]) & (minu[MSB] ^ diff[MSB]);
            end
            OP_INC: begin
                res_o  = step;
                fl_o.v = ~a_i[MSB] & step[MSB];
            end
            default: sel_o = 1'b0;
        endcase
        fl_o.n = res_o[MSB];
        fl_o.z = (res_o == '0);
        if (!sel_o) begin
            fl_o = fl_i;
        end
    end

endmodule

// File: rtl/acc_alu_logic.sv
// acc_alu_logic
// Bitwise and pass-through operations: AND, bit test, exclusive OR,
// inclusive OR, load, test, ones complement and clear. All force V to 0
// and set N and Z from the result; complement also forces C to 1.
// Assumes nothing beyond W >= 1.
module acc_alu_logic
    import acc_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [OP_W-1:0] op_i,
    input  logic [W-1:0]    a_i,
    input  logic [W-1:0]    b_i,
    input  flags_t          fl_i,
    output logic            sel_o,
    output logic [W-1:0]    res_o,
    output flags_t          fl_o
);

    localparam int MSB = W - 1;

    // Result per operation and the common logic-class flag rule.
    always_comb begin
        fl_o  = fl_i;
        sel_o = 1'b1;
        res_o = '0;
        case (op_i)
            OP_AND, OP_BIT: res_o = a_i & b_i;
            OP_EOR:         res_o = a_i ^ b_i;
            OP_ORA:         res_o = a_i | b_i;
            OP_LDA:         res_o = b_i;
            OP_TST:         res_o = a_i;
            OP_COM:         res_o = ~a_i;
            OP_CLR:         res_o = '0;
            default:        sel_o = 1'b0;
        endcase
        if (sel_o) begin
            fl_o.v = 1'b0;
            fl_o.n = res_o[MSB];
            fl_o.z = (res_o == '0);
            if (op_i == OP_COM) begin
                fl_o.c = 1'b1;
            end
        end
    end

endmodule

// File: rtl/acc_alu_shift.sv
// acc_alu_shift
// Single-bit shifts and rotates through carry, plus nibble swap.
// Shifts take C from the bit shifted out and set V = N xor C;
// nibble swap leaves every flag alone.
// Assumes W is even so that the swap splits into equal halves.
module acc_alu_shift
    import acc_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [OP_W-1:0] op_i,
    input  logic [W-1:0]    a_i,
    input  flags_t          fl_i,
    output logic            sel_o,
    output logic [W-1:0]    res_o,
    output flags_t          fl_o
);

    localparam int MSB  = W - 1;
    localparam int HALF = W / 2;

    logic is_shift;

    // Bit rearrangement per operation and carry from the outgoing bit.
    always_comb begin
        fl_o     = fl_i;
        sel_o    = 1'b1;
        is_shift = 1'b1;
        res_o    = a_i;
        case (op_i)
            OP_LSL: begin res_o = {a_i[MSB-1:0], 1'b0};   fl_o.c = a_i[MSB]; end
            OP_ROL: begin res_o = {a_i[MSB-1:0], fl_i.c}; fl_o.c = a_i[MSB]; end
            OP_LSR: begin res_o = {1'b0, a_i[MSB:1]};     fl_o.c = a_i[0];   end
            OP_ROR: begin res_o = {fl_i.c, a_i[MSB:1]};   fl_o.c = a_i[0];   end
            OP_NSA: begin
                res_o    = {a_i[HALF-1:0], a_i[MSB:HALF]};
                is_shift = 1'b0;
            end
            default: begin
                sel_o    = 1'b0;
                is_shift = 1'b0;
            end
        endcase
        if (is_shift) begin
            fl_o.n = res_o[MSB];
            fl_o.z = (res_o == '0);
            fl_o.v = res_o[MSB] ^ fl_o.c;
        end
    end

endmodule

// File: rtl/acc_alu_mul.sv
// acc_alu_mul
// Unsigned W x W multiply built from a generated partial-product array.
// Clears H and C and keeps V, N and Z.
// Assumes the product is consumed as a high byte and a low byte.
module acc_alu_mul
    import acc_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [OP_W-1:0] op_i,
    input  logic [W-1:0]    a_i,
    input  logic [W-1:0]    b_i,
    input  flags_t          fl_i,
    output logic            sel_o,
    output logic [W-1:0]    hi_o,
    output logic [W-1:0]    lo_o,
    output flags_t          fl_o
);

    localparam int PW = 2 * W;

    logic [PW-1:0] pp [W];
    logic [PW-1:0] prod;

    // One shifted copy of a_i per set bit of b_i.
    for (genvar g = 0; g < W; g++) begin : g_pp
        assign pp[g] = b_i[g] ? (PW'(a_i) << g) : '0;
    end

    // Sum the partial products into the full product.
    always_comb begin
        prod = '0;
        for (int k = 0; k < W; k++) begin
            prod = prod + pp[k];
        end
    end

    // Split the product and apply the multiply flag rule.
    always_comb begin
        sel_o = (op_i == OP_MUL);
        hi_o  = prod[PW-1:W];
        lo_o  = prod[W-1:0];
        fl_o  = fl_i;
        if (sel_o) begin
            fl_o.h = 1'b0;
            fl_o.c = 1'b0;
        end
    end

endmodule

// File: rtl/acc_alu.sv
// acc_alu
// Top of the accumulator ALU. Decodes the operation into one of four
// units, merges their results and flags, assembles the condition code
// byte and registers everything for one cycle of latency.
// Assumes at most one operation per cycle; reset is synchronous, active low.
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [OP_W-1:0]  op,
    input  logic [W-1:0]     opa,
    input  logic [W-1:0]     opb,
    input  logic [CCR_W-1:0] ccr_in,
    output logic             out_valid,
    output logic [W-1:0]     res_hi,
    output logic [W-1:0]     res_lo,
    output logic             wr_en,
    output logic [CCR_W-1:0] ccr_out
);

    flags_t       fl_cur;
    flags_t       fl_ar, fl_lg, fl_sh, fl_mu, fl_nxt;
    logic         sel_ar, sel_lg, sel_sh, sel_mu;
    logic [W-1:0] r_ar, r_lg, r_sh, r_mu_hi, r_mu_lo;
    logic [W-1:0] nxt_hi, nxt_lo;
    logic         nxt_wr;
    logic [CCR_W-1:0] nxt_ccr;
    logic         ccr_const_unused;

    // Incoming constant-one bits carry no information.
    assign ccr_const_unused = ^ccr_in[6:5];

    // Unpack the writable flags from the incoming condition code byte.
    always_comb begin
        fl_cur.v = ccr_in[CCR_V];
        fl_cur.h = ccr_in[CCR_H];
        fl_cur.n = ccr_in[CCR_N];
        fl_cur.z = ccr_in[CCR_Z];
        fl_cur.c = ccr_in[CCR_C];
    end

    acc_alu_arith #(.W(W)) u_arith (
        .op_i (op),     .a_i (opa),   .b_i (opb), .fl_i (fl_cur),
        .sel_o(sel_ar), .res_o(r_ar), .fl_o(fl_ar)
    );

    acc_alu_logic #(.W(W)) u_logic (
        .op_i (op),     .a_i (opa),   .b_i (opb), .fl_i (fl_cur),
        .sel_o(sel_lg), .res_o(r_lg), .fl_o(fl_lg)
    );

    acc_alu_shift #(.W(W)) u_shift (
        .op_i (op),     .a_i (opa),   .fl_i (fl_cur),
        .sel_o(sel_sh), .res_o(r_sh), .fl_o(fl_sh)
    );

    acc_alu_mul #(.W(W)) u_mul (
        .op_i (op),     .a_i (opa),    .b_i (opb),     .fl_i(fl_cur),
        .sel_o(sel_mu), .hi_o(r_mu_hi), .lo_o(r_mu_lo), .fl_o(fl_mu)
    );

    // Merge the unit outputs; unassigned codes keep flags and write nothing.
    always_comb begin
        nxt_hi = '0;
        nxt_lo = '0;
        fl_nxt = fl_cur;
        if (sel_ar) begin
            nxt_lo = r_ar;
            fl_nxt = fl_ar;
        end else if (sel_lg) begin
            nxt_lo = r_lg;
            fl_nxt = fl_lg;
        end else if (sel_sh) begin
            nxt_lo = r_sh;
            fl_nxt = fl_sh;
        end else if (sel_mu) begin
            nxt_hi = r_mu_hi;
            nxt_lo = r_mu_lo;
            fl_nxt = fl_mu;
        end
        nxt_wr = (sel_ar | sel_lg | sel_sh | sel_mu)
               && (op != OP_CMP) && (op != OP_BIT) && (op != OP_TST);
    end

    // Assemble the outgoing condition code byte at its fixed bit positions.
    always_comb begin
        nxt_ccr        = CCR_ONES;
        nxt_ccr[CCR_V] = fl_nxt.v;
        nxt_ccr[CCR_H] = fl_nxt.h;
        nxt_ccr[CCR_I] = ccr_in[CCR_I];
        nxt_ccr[CCR_N] = fl_nxt.n;
        nxt_ccr[CCR_Z] = fl_nxt.z;
        nxt_ccr[CCR_C] = fl_nxt.c;
    end

    // Output register stage: one cycle from operation to result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            res_hi    <= '0;
            res_lo    <= '0;
            wr_en     <= 1'b0;
            ccr_out   <= CCR_ONES;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                res_hi  <= nxt_hi;
                res_lo  <= nxt_lo;
                wr_en   <= nxt_wr;
                ccr_out <= nxt_ccr;
            end else begin
                wr_en   <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/acc_alu_chk.sv
// acc_alu_chk
// Property checker for acc_alu, bound to every instance of the top.
// Relates registered outputs to the inputs of the previous cycle.
module acc_alu_chk
    import acc_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [OP_W-1:0]  op,
    input logic [W-1:0]     opa,
    input logic [W-1:0]     opb,
    input logic [CCR_W-1:0] ccr_in,
    input logic             out_valid,
    input logic [W-1:0]     res_hi,
    input logic [W-1:0]     res_lo,
    input logic             wr_en,
    input logic [CCR_W-1:0] ccr_out
);

    localparam int PW = 2 * W;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);                                              // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !wr_en));                                // R1
    AST_FIXED_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (ccr_out[6:5] == 2'b11));                               // R2
    AST_I_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (ccr_out[CCR_I] == $past(ccr_in[CCR_I])));               // R2
    AST_H_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op != OP_MUL) |=> (ccr_out[CCR_H] == $past(ccr_in[CCR_H]))); // R2
    AST_CMP_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_CMP) |=> !wr_en);                               // R3
    AST_TEST_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == OP_BIT || op == OP_TST)) |=> (!wr_en && !ccr_out[CCR_V])); // R6
    AST_COM_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_COM) |=> (ccr_out[CCR_C] && !ccr_out[CCR_V]));  // R7
    AST_CLR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_CLR) |=> (res_lo == '0 && ccr_out[CCR_Z]
                                        && !ccr_out[CCR_N] && !ccr_out[CCR_V])); // R8
    AST_LSR_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_LSR) |=> (!ccr_out[CCR_N]
                                        && ccr_out[CCR_C] == $past(opa[0]))); // R10
    AST_MUL_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_MUL) |=> ({res_hi, res_lo}
                                        == PW'($past(opa)) * PW'($past(opb))
                                        && !ccr_out[CCR_H] && !ccr_out[CCR_C])); // R12
    AST_UNASSIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op > OP_MUL) |=> (!wr_en && res_lo == '0
                                       && ccr_out == ($past(ccr_in) | CCR_ONES))); // R13

endmodule

bind acc_alu acc_alu_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .opa(opa),
    .opb(opb), .ccr_in(ccr_in), .out_valid(out_valid), .res_hi(res_hi),
    .res_lo(res_lo), .wr_en(wr_en), .ccr_out(ccr_out)
);

// File: tb/acc_alu_tb.sv
// acc_alu_tb
// Scoreboard bench: the driver predicts each result with a reference
// model written from the requirements and queues it; the monitor pops
// and compares when the design presents a result.
module acc_alu_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 400;
    localparam int WATCHDOG   = 150000;

    typedef struct packed {
        logic [4:0] op;
        logic       wr;
        logic [7:0] hi;
        logic [7:0] lo;
        logic [7:0] ccr;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [4:0] op = '0;
    logic [7:0] opa = '0;
    logic [7:0] opb = '0;
    logic [7:0] ccr_in = '0;
    logic       out_valid;
    logic [7:0] res_hi;
    logic [7:0] res_lo;
    logic       wr_en;
    logic [7:0] ccr_out;

    int   n_checks = 0;
    int   n_fails  = 0;
    bit   done     = 1'b0;
    exp_t exp_q[$];

    acc_alu u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .opa(opa),
        .opb(opb), .ccr_in(ccr_in), .out_valid(out_valid), .res_hi(res_hi),
        .res_lo(res_lo), .wr_en(wr_en), .ccr_out(ccr_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Requirement tag for each operation code.
    function automatic string req_of(input logic [4:0] o);
        case (o)
            5'd0, 5'd1, 5'd2:                 return "R3";
            5'd3:                             return "R4";
            5'd4, 5'd5:                       return "R5";
            5'd6, 5'd7, 5'd8, 5'd9, 5'd10, 5'd11: return "R6";
            5'd12:                            return "R7";
            5'd13:                            return "R8";
            5'd14, 5'd16:                     return "R9";
            5'd15, 5'd17:                     return "R10";
            5'd18:                            return "R11";
            5'd19:                            return "R12";
            default:                          return "R13";
        endcase
    endfunction

    // Reference model from the requirements.
    function automatic exp_t model(input logic [4:0] o, input logic [7:0] a,
                                   input logic [7:0] b, input logic [7:0] ci);
        exp_t e;
        logic v, h, n, z, c, upd, shift;
        int   t, sv, cin;
        logic [15:0] p;
        v = ci[7]; h = ci[4]; n = ci[2]; z = ci[1]; c = ci[0];
        e.op = o; e.wr = 1'b1; e.hi = 8'h00; e.lo = 8'h00;
        upd = 1'b1; shift = 1'b0;
        case (o)
            5'd0, 5'd1, 5'd2: begin
                cin  = (o == 5'd1) ? int'(c) : 0;
                t    = int'(a) - int'(b) - cin;
                sv   = int'($signed(a)) - int'($signed(b)) - cin;
                e.lo = t[7:0];
                c    = (t < 0);
                v    = (sv < -128) || (sv > 127);
                e.wr = (o != 5'd2);
            end
            5'd3:  begin e.lo = 8'h00 - a; c = (a != 8'h00); v = (a == 8'h80); end
            5'd4:  begin e.lo = a + 8'h01; v = (a == 8'h7F); end
            5'd5:  begin e.lo = a - 8'h01; v = (a == 8'h80); end
            5'd6:  begin e.lo = a & b; v = 1'b0; end
            5'd7:  begin e.lo = a & b; v = 1'b0; e.wr = 1'b0; end
            5'd8:  begin e.lo = a ^ b; v = 1'b0; end
            5'd9:  begin e.lo = a | b; v = 1'b0; end
            5'd10: begin e.lo = b; v = 1'b0; end
            5'd11: begin e.lo = a; v = 1'b0; e.wr = 1'b0; end
            5'd12: begin e.lo = ~a; v = 1'b0; c = 1'b1; end
            5'd13: begin e.lo = 8'h00; v = 1'b0; end
            5'd14: begin e.lo = {a[6:0], 1'b0}; c = a[7]; shift = 1'b1; end
            5'd16: begin e.lo = {a[6:0], c};    c = a[7]; shift = 1'b1; end
            5'd15: begin e.lo = {1'b0, a[7:1]}; c = a[0]; shift = 1'b1; end
            5'd17: begin e.lo = {c, a[7:1]};    c = a[0]; shift = 1'b1; end
            5'd18: begin e.lo = {a[3:0], a[7:4]}; upd = 1'b0; end
            5'd19: begin
                p = 16'(a) * 16'(b);
                e.hi = p[15:8]; e.lo = p[7:0];
                h = 1'b0; c = 1'b0; upd = 1'b0;
            end
            default: begin e.wr = 1'b0; upd = 1'b0; end
        endcase
        if (upd) begin
            n = e.lo[7];
            z = (e.lo == 8'h00);
        end
        if (shift) v = n ^ c;
        e.ccr = {v, 2'b11, h, ci[3], n, z, c};
        return e;
    endfunction

    // Driver: present one operation and queue its predicted result.
    task automatic drive(input logic [4:0] o, input logic [7:0] a,
                         input logic [7:0] b, input logic [7:0] ci);
        @(negedge clk);
        in_valid = 1'b1; op = o; opa = a; opb = b; ccr_in = ci;
        exp_q.push_back(model(o, a, b, ci));
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    endtask

    // Monitor: compare each presented result against the queue head.
    always @(posedge clk) begin
        exp_t e;
        #2;
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                n_checks++; n_fails++;
                $display("FAIL R1 unexpected result: actual out_valid=1 expected out_valid=0");
            end else begin
                e = exp_q.pop_front();
                n_checks++;
                if ({wr_en, res_hi, res_lo, ccr_out} != {e.wr, e.hi, e.lo, e.ccr}) begin
                    n_fails++;
                    $display("FAIL %s op=%0d actual wr=%0b hi=%02h lo=%02h ccr=%02h expected wr=%0b hi=%02h lo=%02h ccr=%02h",
                             req_of(e.op), e.op, wr_en, res_hi, res_lo, ccr_out,
                             e.wr, e.hi, e.lo, e.ccr);
                end
                n_checks++;
                if (ccr_out[6:5] != 2'b11 || ccr_out[3] != e.ccr[3] || ccr_out[4] != e.ccr[4]) begin
                    n_fails++;
                    $display("FAIL R2 layout op=%0d actual ccr=%02h expected ccr=%02h",
                             e.op, ccr_out, e.ccr);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL R1 watchdog expired: actual running expected finished");
        summary();
    end

    // Stimulus sequence.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        n_checks++;
        if ({out_valid, wr_en, res_hi, res_lo, ccr_out} != {1'b0, 1'b0, 8'h00, 8'h00, 8'h60}) begin
            n_fails++;
            $display("FAIL R1 reset actual v=%0b wr=%0b hi=%02h lo=%02h ccr=%02h expected 0 0 00 00 60",
                     out_valid, wr_en, res_hi, res_lo, ccr_out);
        end
        // R3: signed overflow, borrow, equal compare, borrow-in alone
        drive(5'd0, 8'h80, 8'h01, 8'h00);
        drive(5'd0, 8'h10, 8'h20, 8'h00);
        drive(5'd2, 8'h55, 8'h55, 8'h01);
        drive(5'd1, 8'h42, 8'h42, 8'h01);
        drive(5'd1, 8'h00, 8'hFF, 8'h00);
        // R4: negate edges
        drive(5'd3, 8'h80, 8'h00, 8'h00);
        drive(5'd3, 8'h00, 8'h00, 8'h01);
        // R5: step overflow, carry kept
        drive(5'd4, 8'h7F, 8'h00, 8'h01);
        drive(5'd5, 8'h80, 8'h00, 8'h00);
        drive(5'd5, 8'h00, 8'h00, 8'h01);
        // R6: logic class with V set beforehand
        drive(5'd7, 8'hF0, 8'h0F, 8'h81);
        drive(5'd11, 8'h00, 8'hAA, 8'h80);
        drive(5'd10, 8'h11, 8'h9C, 8'h9B);
        // R7, R8
        drive(5'd12, 8'hFF, 8'h00, 8'h80);
        drive(5'd13, 8'h5A, 8'h00, 8'h85);
        // R9, R10: rotations carry the old C in
        drive(5'd14, 8'h80, 8'h00, 8'h00);
        drive(5'd16, 8'h40, 8'h00, 8'h01);
        drive(5'd15, 8'h01, 8'h00, 8'h04);
        drive(5'd17, 8'h02, 8'h00, 8'h01);
        // R11: flags all kept
        drive(5'd18, 8'h3C, 8'h00, 8'h9F);
        drive(5'd18, 8'hA5, 8'h00, 8'h00);
        // R12: extremes
        drive(5'd19, 8'hFF, 8'hFF, 8'h1F);
        drive(5'd19, 8'h00, 8'h37, 8'h86);
        // R13: unassigned codes
        drive(5'd20, 8'h12, 8'h34, 8'h9A);
        drive(5'd31, 8'hFF, 8'hFF, 8'h15);
        idle();
        idle();
        // Random operands, codes and incoming flags.
        for (int i = 0; i < N_RANDOM; i++) begin
            logic [4:0] o;
            o = (i % 16 == 15) ? 5'(20 + ($urandom % 12)) : 5'($urandom % 20);
            drive(o, 8'($urandom), 8'($urandom), 8'($urandom));
            if (i % 37 == 0) idle();
        end
        idle();
        repeat (5) @(negedge clk);
        n_checks++;
        if (exp_q.size() != 0) begin
            n_fails++;
            $display("FAIL R1 results missing: actual %0d pending expected 0", exp_q.size());
        end
        summary();
    end

endmodule